// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that gives a bus master access to a small bank of 8-bit registers. It oversamples SCL and SDA with the system clock, finds START, repeated START and STOP conditions, and matches a 7-bit device address. A strap input selects one of two fixed addresses. The block drives SDA only through an open-drain enable, which pulls the line low when it is high.

A write transaction sends the address byte with the direction bit clear, then a register index, then one data byte. A read transaction first writes the register index. A repeated START follows, then the address byte with the direction bit set, and the target returns one byte from the indexed register. The host side of the chip can read any register at any time through a parallel combinational port.

The system clock must run at least eight times faster than SCL. Clock stretching, 10-bit addressing, general call and multi-byte auto-increment are not supported.

Top module: `i2c_regbank_target`

## Requirements
- R1: The address byte carries the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). The device address is 0x60 when `addr_sel` is 0 and 0x61 when it is 1. A matching address byte is acknowledged by pulling SDA low during the ninth clock.
- R2: After an address byte that does not match, the target gives no acknowledge. It keeps SDA released for every following clock until the next START or STOP, and no register changes.
- R3: In a write, the index byte and the data byte are each acknowledged. The data byte is stored in the indexed register. Every byte is shifted in most significant bit first.
- R4: A write carries exactly one data byte. Any further byte before STOP is not acknowledged and changes no register.
- R5: An index write, then a repeated START, then the address byte with bit 0 set, makes the target return the indexed register most significant bit first. The target releases SDA during the ninth clock, in which the master sends its acknowledge bit.
- R6: The target changes its SDA drive only while SCL is low, except when a START or STOP forces the release.
- R7: Index values at or above the bank size (8) are acknowledged. Writes to them are ignored and do not alias onto a lower register. Reads of them return 0x00 on both the bus and the host port.
- R8: A START or STOP at any point, including in the middle of a byte, restarts bit and byte counting. After a STOP the target releases SDA on the next clock.
- R9: After reset, SDA is released, every register reads 0x00, and the stored index is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL bus line |
| sda_i | input | 1 | Sampled SDA bus line |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| addr_sel | input | 1 | Strap: 0 selects address 0x60, 1 selects 0x61 |
| host_raddr | input | 8 | Host-side register index to read |
| host_rdata | output | 8 | Contents of the register at `host_raddr`, or 0x00 if out of range |

## Verification
On every cycle the assertions check four things. SDA drive changes only while the synchronized SCL is low. A STOP always releases the line on the next cycle. The target never drives SDA outside an acknowledge slot or a read-data byte. The host port reads zero for out-of-range indices. Only the bench scenarios can show the rest: acknowledge and no-acknowledge against each strap value, MSB-first storage and return of data, that a surplus write byte and a mismatched transaction leave the registers untouched, that index 9 does not alias onto register 1, and that a START in the middle of a byte restarts framing cleanly.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C register target.
// Assumes byte-wide bus transfers and an 8-bit register index.
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_IDX,
        ST_ACK_IDX,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives SCL
// edges and START/STOP events. Assumes both lines idle high and a system
// clock well above the SCL rate, so each bus phase spans several samples.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_q;
    logic          sda_q;

    // Shift both lines through the synchronizer and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_q    <= scl_pipe[LAST];
            sda_q    <= sda_pipe[LAST];
        end
    end

    assign scl_s     = scl_pipe[LAST];
    assign sda_s     = sda_pipe[LAST];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
// Register file with one write port from the bus sequencer and two
// combinational read ports (bus and host). Indices at or above NUM_REGS
// are not stored and read as zero.
module i2c_reg_bank #(
    parameter int NUM_REGS = 8,
    parameter int IDX_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] bus_ridx,
    output logic [7:0]       bus_rdata,
    input  logic [IDX_W-1:0] host_ridx,
    output logic [7:0]       host_rdata
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

    logic [7:0] regs [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            // Store the write data when this register is addressed.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    // Bus read port, zero outside the bank.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (bus_ridx < LIMIT && bus_ridx == IDX_W'(i))
                bus_rdata = regs[i];
    end

    // Host read port, zero outside the bank.
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (host_ridx < LIMIT && host_ridx == IDX_W'(i))
                host_rdata = regs[i];
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte-level protocol sequencer: shifts in address, index and data bytes,
// drives acknowledges and read data through the open-drain enable.
// Assumes synchronized line levels and single-cycle edge/condition strobes.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] ADDR_LO = 7'h60,
    parameter logic [6:0] ADDR_HI = 7'h61
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       addr_sel,
    input  logic [7:0] rd_data,
    output logic [7:0] reg_idx,
    output logic [7:0] wr_data,
    output logic       wr_en,
    output logic       sda_oe,
    output tgt_state_t state
);
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       is_read;
    logic [6:0] dev_addr;

    assign dev_addr = addr_sel ? ADDR_HI : ADDR_LO;
    assign wr_data  = shreg;

    // Advance the transaction state on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            tx      <= '0;
            is_read <= 1'b0;
            reg_idx <= '0;
            wr_en   <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_DEV, ST_IDX, ST_WDATA: begin
                        if (scl_rise && cnt != 4'd8) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (shreg[7:1] == dev_addr) begin
                                    sda_oe  <= 1'b1;
                                    is_read <= shreg[0];
                                    state   <= ST_ACK_DEV;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_IDX) begin
                                reg_idx <= shreg;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK_IDX;
                            end else begin
                                wr_en  <= 1'b1;
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_WDATA;
                            end
                        end
                    end
                    ST_ACK_DEV: begin
                        if (scl_fall) begin
                            if (is_read) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt    <= '0;
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDX;
                            end
                        end
                    end
                    ST_ACK_IDX: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_ACK_WDATA: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                cnt    <= cnt + 4'd1;
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall)
                            state <= ST_IGNORE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regbank_target.sv
// Top level of the I2C register target: line synchronizer, protocol
// sequencer and register bank. Assumes clk runs at least 8x SCL.
module i2c_regbank_target
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] ADDR_LO     = 7'h60,
    parameter logic [6:0] ADDR_HI     = 7'h61
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic [7:0] host_raddr,
    output logic [7:0] host_rdata
);
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [7:0] reg_idx;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       wr_en;
    tgt_state_t fsm_state;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .addr_sel(addr_sel), .rd_data(rd_data), .reg_idx(reg_idx),
        .wr_data(wr_data), .wr_en(wr_en), .sda_oe(sda_oe),
        .state(fsm_state)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(8)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(reg_idx),
        .wr_data(wr_data), .bus_ridx(reg_idx), .bus_rdata(rd_data),
        .host_ridx(host_raddr), .host_rdata(host_rdata)
    );
endmodule

// File: rtl/i2c_regbank_target_chk.sv
// Protocol checker for the I2C register target, bound to the top module.
module i2c_regbank_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input tgt_state_t fsm_state,
    input logic [7:0] host_raddr,
    input logic [7:0] host_rdata
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s); // R6

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe); // R8

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE || fsm_state == ST_IDLE) |-> !sda_oe); // R2

    AST_DRIVE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (fsm_state == ST_ACK_DEV || fsm_state == ST_ACK_IDX ||
                    fsm_state == ST_ACK_WDATA || fsm_state == ST_RDATA)); // R3

    AST_HOST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(host_raddr) >= NUM_REGS) |-> host_rdata == 8'h00); // R7
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
    .stop_det(stop_det), .sda_oe(sda_oe), .fsm_state(fsm_state),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
);

// File: tb/i2c_regbank_target_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module i2c_regbank_target_bench;
    localparam time CLK_HALF = 10ns;
    localparam time Q        = 200ns;

    typedef struct {
        int         req;
        logic [7:0] val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       addr_sel = 1'b0;
    logic [7:0] host_raddr = 8'h00;
    logic [7:0] host_rdata;

    item_t      exp_q[$];
    logic [7:0] obs_val;
    event       obs_ev;
    int         checks = 0;
    int         errors = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #CLK_HALF clk = ~clk;

    i2c_regbank_target u_i2c_regbank_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(addr_sel),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    // Monitor: pop the oldest expectation and compare with the observation.
    initial begin
        forever begin
            @(obs_ev);
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R0 actual %h expected <none>", obs_val);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                if (obs_val !== it.val) begin
                    errors++;
                    $display("FAIL R%0d actual %h expected %h", it.req, obs_val, it.val);
                end
            end
        end
    end

    task automatic expect_item(input int req, input logic [7:0] val);
        exp_q.push_back('{req, val});
    endtask

    task automatic observe(input logic [7:0] v);
        obs_val = v;
        ->obs_ev;
        #1;
    endtask

    task automatic start_cond();
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b0; #Q;
        scl = 1'b0;   #Q;
    endtask

    task automatic stop_cond();
        sda_m = 1'b0; #Q;
        scl = 1'b1;   #Q;
        sda_m = 1'b1; #(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; #Q;
        scl = 1'b1; #(2*Q);
        scl = 1'b0; #Q;
    endtask

    // Send a byte; queue expected acknowledge (1 = acked) and observe it.
    task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input int req);
        expect_item(req, {7'b0, exp_ack});
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        observe({7'b0, ~sda_line});
        #(Q-1);
        scl = 1'b0;   #Q;
    endtask

    // Read a byte, then NACK and check the target released SDA.
    task automatic rd_byte(input logic [7:0] exp, input int req);
        logic [7:0] v = '0;
        expect_item(req, exp);
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; #Q;
            scl = 1'b1;   #Q;
            v = {v[6:0], sda_line};
            #Q;
            scl = 1'b0;   #Q;
        end
        observe(v);
        expect_item(5, 8'h01); // R5: SDA released in master's ack clock
        sda_m = 1'b1; #Q;
        scl = 1'b1;   #Q;
        observe({7'b0, sda_line});
        #(Q-1);
        scl = 1'b0;   #Q;
    endtask

    task automatic host_check(input logic [7:0] idx, input logic [7:0] exp, input int req);
        expect_item(req, exp);
        host_raddr = idx;
        #1;
        observe(host_rdata);
    endtask

    task automatic bus_write(input logic [6:0] dev, input logic [7:0] idx,
                             input logic [7:0] d, input int req);
        start_cond();
        wr_byte({dev, 1'b0}, 1'b1, 1);  // R1
        wr_byte(idx, 1'b1, req);
        wr_byte(d, 1'b1, req);
        stop_cond();
    endtask

    task automatic bus_read(input logic [6:0] dev, input logic [7:0] idx,
                            input logic [7:0] exp, input int req);
        start_cond();
        wr_byte({dev, 1'b0}, 1'b1, 1);  // R1
        wr_byte(idx, 1'b1, req);
        start_cond();
        wr_byte({dev, 1'b1}, 1'b1, 1);  // R1
        rd_byte(exp, req);
        stop_cond();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_HALF * 2 * 150000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        #100;
        rst_n = 1'b1;
        #Q;
        // R9: reset state
        expect_item(9, 8'h01);
        observe({7'b0, sda_line});
        host_check(8'd0, 8'h00, 9); // R9
        host_check(8'd7, 8'h00, 9); // R9

        // R1 / R3: write with strap low
        bus_write(7'h60, 8'd2, 8'hA5, 3);
        host_check(8'd2, 8'hA5, 3); // R3
        // R5: read back through repeated START
        bus_read(7'h60, 8'd2, 8'hA5, 5);
        // R3: MSB-first pattern
        bus_write(7'h60, 8'd7, 8'h81, 3);
        host_check(8'd7, 8'h81, 3); // R3
        bus_read(7'h60, 8'd7, 8'h81, 5); // R5

        // R4: surplus data byte is refused and changes nothing
        start_cond();
        wr_byte(8'hC0, 1'b1, 1);  // R1
        wr_byte(8'h03, 1'b1, 4);  // R4
        wr_byte(8'h5A, 1'b1, 4);  // R4
        wr_byte(8'hFF, 1'b0, 4);  // R4
        stop_cond();
        host_check(8'd3, 8'h5A, 4); // R4

        // R2: strap high, old address no longer matches
        addr_sel = 1'b1;
        start_cond();
        wr_byte(8'hC0, 1'b0, 2);  // R2
        wr_byte(8'h04, 1'b0, 2);  // R2
        wr_byte(8'h77, 1'b0, 2);  // R2
        stop_cond();
        host_check(8'd4, 8'h00, 2); // R2
        bus_write(7'h61, 8'd4, 8'h77, 1); // R1
        host_check(8'd4, 8'h77, 1); // R1
        bus_read(7'h61, 8'd4, 8'h77, 5); // R5

        // R7: out-of-range index
        bus_write(7'h61, 8'd9, 8'h99, 7);
        host_check(8'd9, 8'h00, 7); // R7
        host_check(8'd1, 8'h00, 7); // R7 no aliasing
        bus_read(7'h61, 8'd9, 8'h00, 7); // R7

        // R8: START in the middle of an address byte
        start_cond();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        start_cond();
        wr_byte(8'hC2, 1'b1, 8);  // R8
        wr_byte(8'h06, 1'b1, 8);  // R8
        wr_byte(8'h3C, 1'b1, 8);  // R8
        stop_cond();
        host_check(8'd6, 8'h3C, 8); // R8

        // R8: STOP in the middle of an index byte
        start_cond();
        wr_byte(8'hC2, 1'b1, 8);  // R8
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        stop_cond();
        expect_item(8, 8'h01);    // R8 line released
        observe({7'b0, sda_line});
        host_check(8'd0, 8'h00, 8); // R8
        bus_write(7'h61, 8'd0, 8'h42, 8); // R8 framing recovered
        host_check(8'd0, 8'h42, 8); // R8

        #Q;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R0 actual %0d expected 0 pending items", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule